// File: doc/BRIEF.md
# Majority Vote Input Glitch Filter

This block cleans up the three incoming lines of one incremental encoder channel (phase A, phase B and index) before they reach a quadrature decoder. Each raw line is first brought into the system clock domain by a short flop chain. It then feeds a small shift history. That history advances only on cycles where a sample-rate enable is high, so the filter runs at a programmable sample rate below the system clock. The filtered value of each line is the majority of the samples held in its history. A level that shows up in only one sample therefore never reaches the decoder.

The vote delays every edge by about two sample intervals. Some systems merge the quadrature count with interpolated sub-count data that arrives on a parallel path, and for them that delay breaks alignment. A bypass input removes the delay: when it is set, the synchronized raw lines drive the outputs directly and the vote is skipped. The history keeps advancing in both modes, so turning the filter back on gives a vote over current samples.

The history depth (odd, at least three) and the synchronizer length are parameters. With the default depth of three, the vote uses a fixed two-of-three gate; deeper histories use a population count.

Top module: `enc_glitch_filter`

## Requirements
- R1: While reset is asserted, and right after its release, all three filtered outputs are 0. The synchronizer flops and the history are cleared to 0.
- R2: A raw line reaches its synchronized form after exactly SYNC_STAGES (default 2) rising clock edges, whatever the state of the sample enable. With bypass set, that synchronized value is what the output shows.
- R3: On a cycle where the sample enable is low, the history does not change, so the output does not change while the filter is on.
- R4: On each rising edge where the sample enable is high, the current synchronized value of the line enters the history as its newest sample.
- R5: While the filter is on, each output equals the majority value of the three most recent samples of its line.
- R6: While the filter is on, a level that is caught by a single sample between samples of the opposite level never changes that line's output.
- R7: While the filter is on, a clean level change shows at the output right after the second enabled edge that samples the new level. Earlier than that, the output keeps the old level.
- R8: The bypass input set to 0 selects the filtered value and set to 1 selects the synchronized raw value. The history keeps advancing on enabled edges in both modes.
- R9: The three lines are filtered independently: activity on one line never changes another line's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_a | input | 1 | Unsynchronized phase A line |
| raw_b | input | 1 | Unsynchronized phase B line |
| raw_idx | input | 1 | Unsynchronized index line |
| smp_en | input | 1 | One-cycle strobe at the filter sample rate |
| bypass | input | 1 | 1 = skip the vote, 0 = filter active |
| flt_a | output | 1 | Conditioned phase A |
| flt_b | output | 1 | Conditioned phase B |
| flt_idx | output | 1 | Conditioned index |

## Verification
The bench aims at the cases where the vote timing is easy to get wrong. A single-sample pulse must leave the output unchanged; a design that took the newest sample or an OR of the history would pass it through. A step edge must appear after exactly the second enabled sample; a design with an off-by-one shift or an extra register would move the edge. Cycles with the enable low must leave the output frozen, which a history clocked without the enable would break. A long sweep that toggles all inputs, the enable and the bypass bit is compared against an arithmetic model of the sync chain and the vote. That sweep catches crossed lines, an inverted bypass polarity, and a history that stops advancing during bypass.

// File: rtl/enc_glitch_filter_pkg.sv
package enc_glitch_filter_pkg;

   // Line positions inside the packed line vector
   localparam int unsigned LINE_A   = 0;
   localparam int unsigned LINE_B   = 1;
   localparam int unsigned LINE_IDX = 2;
   localparam int unsigned N_LINES  = 3;

   typedef logic [N_LINES-1:0] line_vec_t;

   // Fixed two-of-three vote
   function automatic logic vote3(input logic [2:0] s);
      return (s[0] & s[1]) | (s[1] & s[2]) | (s[0] & s[2]);
   endfunction

endpackage

// File: rtl/egf_sync.sv
module egf_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("egf_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];

   // R2: each flop of the chain takes its neighbour's value one edge later
   p_first_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> chain[0] == $past(din));

   for (genvar i = 1; i < STAGES; i++) begin : g_stage_chk
      p_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |=> chain[i] == $past(chain[i-1]));
   end

endmodule

// File: rtl/egf_vote.sv
module egf_vote
   import enc_glitch_filter_pkg::*;
#(
   parameter int unsigned DEPTH = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_en,
   input  logic din,
   output logic vote
);

   if (DEPTH < 3 || (DEPTH % 2) == 0) begin : g_bad_depth
      $error("egf_vote: DEPTH must be odd and at least 3");
   end

   localparam int unsigned CW   = $clog2(DEPTH + 1);
   localparam int unsigned HALF = DEPTH / 2;

   logic [DEPTH-1:0] hist;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hist <= '0;
      else if (smp_en) hist <= {hist[DEPTH-2:0], din};
   end

   if (DEPTH == 3) begin : g_vote3
      assign vote = vote3(hist);
   end else begin : g_vote_count
      logic [CW-1:0] ones;
      always_comb begin
         ones = '0;
         for (int i = 0; i < DEPTH; i++) ones = ones + CW'(hist[i]);
      end
      assign vote = (ones > CW'(HALF));
   end

   // R3: no enable, no change in history or vote
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_en |=> $stable(hist) && $stable(vote));

   // R4: an enabled edge loads the synchronized value as newest sample
   p_newest_r4: assert property (@(posedge clk) disable iff (!rst_n)
      smp_en |=> hist[0] == $past(din));

   // R6: if the older retained samples agree, one new sample cannot flip the vote
   p_glitch_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_en && ((&hist[DEPTH-2:0]) || !(|hist[DEPTH-2:0])))
         |=> vote == $past(hist[0]));

endmodule

// File: rtl/enc_glitch_filter.sv
module enc_glitch_filter
   import enc_glitch_filter_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned VOTE_DEPTH  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_a,
   input  logic raw_b,
   input  logic raw_idx,
   input  logic smp_en,
   input  logic bypass,
   output logic flt_a,
   output logic flt_b,
   output logic flt_idx
);

   line_vec_t raw_v, sync_v, vote_v, out_v;

   assign raw_v[LINE_A]   = raw_a;
   assign raw_v[LINE_B]   = raw_b;
   assign raw_v[LINE_IDX] = raw_idx;

   for (genvar l = 0; l < N_LINES; l++) begin : g_line
      egf_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (raw_v[l]),
         .dout (sync_v[l])
      );

      egf_vote #(.DEPTH(VOTE_DEPTH)) u_vote (
         .clk   (clk),
         .rst_n (rst_n),
         .smp_en(smp_en),
         .din   (sync_v[l]),
         .vote  (vote_v[l])
      );
   end

   assign out_v   = bypass ? sync_v : vote_v;
   assign flt_a   = out_v[LINE_A];
   assign flt_b   = out_v[LINE_B];
   assign flt_idx = out_v[LINE_IDX];

   // R1: outputs are low in the first cycle after reset release
   p_reset_low_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> out_v == '0);

   // R3: with the filter active and no enable, outputs hold
   p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_en && !bypass) |=> (!bypass -> $stable(out_v)));

endmodule

// File: tb/enc_glitch_filter_test.sv
module enc_glitch_filter_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic raw_a = 1'b0, raw_b = 1'b0, raw_idx = 1'b0;
   logic smp_en = 1'b0, bypass = 1'b0;
   logic flt_a, flt_b, flt_idx;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   // bench model state, per line: sync stages and history
   logic [2:0] m_s1 = '0, m_s2 = '0;
   logic [2:0] m_h0 = '0, m_h1 = '0, m_h2 = '0;

   always #5 clk = ~clk;

   enc_glitch_filter uut (
      .clk(clk), .rst_n(rst_n), .raw_a(raw_a), .raw_b(raw_b), .raw_idx(raw_idx),
      .smp_en(smp_en), .bypass(bypass),
      .flt_a(flt_a), .flt_b(flt_b), .flt_idx(flt_idx)
   );

   task automatic chk(input logic got, input logic exp, input string tag);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic [2:0] model_out();
      logic [2:0] r;
      for (int l = 0; l < 3; l++)
         r[l] = bypass ? m_s2[l]
                       : ((m_h0[l] & m_h1[l]) | (m_h1[l] & m_h2[l]) | (m_h0[l] & m_h2[l]));
      return r;
   endfunction

   // compare all outputs against the model (called at negedge)
   task automatic cmp_all(input string tag);
      logic [2:0] e;
      e = model_out();
      chk(flt_a,   e[0], tag);
      chk(flt_b,   e[1], tag);
      chk(flt_idx, e[2], tag);
   endtask

   // apply inputs at negedge, advance model by one rising edge, land on next negedge
   task automatic step(input logic [2:0] raw, input logic en, input logic byp);
      raw_a = raw[0]; raw_b = raw[1]; raw_idx = raw[2];
      smp_en = en; bypass = byp;
      if (en) begin
         m_h2 = m_h1; m_h1 = m_h0; m_h0 = m_s2;
      end
      m_s2 = m_s1; m_s1 = raw;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      repeat (3) @(negedge clk);
      // R1: outputs low during reset
      chk(flt_a, 1'b0, "R1"); chk(flt_b, 1'b0, "R1"); chk(flt_idx, 1'b0, "R1");
      raw_a = 1'b1; raw_b = 1'b1; raw_idx = 1'b1; smp_en = 1'b1;
      @(negedge clk);
      chk(flt_a, 1'b0, "R1"); chk(flt_idx, 1'b0, "R1");
      raw_a = 1'b0; raw_b = 1'b0; raw_idx = 1'b0; smp_en = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      cmp_all("R1");

      // R2: bypass latency of two edges, enable held low
      step(3'b101, 1'b0, 1'b1);
      chk(flt_a, 1'b0, "R2"); chk(flt_idx, 1'b0, "R2");
      step(3'b101, 1'b0, 1'b1);
      chk(flt_a, 1'b1, "R2"); chk(flt_idx, 1'b1, "R2"); chk(flt_b, 1'b0, "R2");
      step(3'b000, 1'b0, 1'b1);
      step(3'b000, 1'b0, 1'b1);
      chk(flt_a, 1'b0, "R2");

      // R7: clean step on B, filter on
      step(3'b010, 1'b0, 1'b0);
      step(3'b010, 1'b0, 1'b0);
      step(3'b010, 1'b1, 1'b0);   // first enabled edge sampling the new level
      chk(flt_b, 1'b0, "R7");
      step(3'b010, 1'b0, 1'b0);
      chk(flt_b, 1'b0, "R3");    // no enable: held
      step(3'b010, 1'b1, 1'b0);   // second enabled edge
      chk(flt_b, 1'b1, "R7");
      chk(flt_a, 1'b0, "R9"); chk(flt_idx, 1'b0, "R9");
      cmp_all("R5");

      // R6: single-sample pulse on A with enable every cycle
      step(3'b011, 1'b1, 1'b0);
      for (int k = 0; k < 6; k++) begin
         step(3'b010, 1'b1, 1'b0);
         chk(flt_a, 1'b0, "R6");
         chk(flt_b, 1'b1, "R9");
      end
      // R6: single-sample dropout on B
      step(3'b000, 1'b1, 1'b0);
      for (int k = 0; k < 6; k++) begin
         step(3'b010, 1'b1, 1'b0);
         chk(flt_b, 1'b1, "R6");
      end

      // R8: history advances under bypass, vote valid when filter returns
      for (int k = 0; k < 5; k++) step(3'b100, 1'b1, 1'b1);
      chk(flt_idx, 1'b1, "R8"); chk(flt_b, 1'b0, "R8");
      step(3'b100, 1'b0, 1'b0);
      chk(flt_idx, 1'b1, "R8"); chk(flt_b, 1'b0, "R8");

      // exhaustive input patterns, then long pseudo-random sweep
      for (int p = 0; p < 32; p++)
         for (int r = 0; r < 3; r++) begin
            step(p[2:0], p[3], p[4]);
            cmp_all("R5");
         end
      for (int n = 0; n < 20000; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[2:0], lfsr[4] | lfsr[5], lfsr[9] & lfsr[11] & lfsr[7]);
         cmp_all(bypass ? "R8" : "R5");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule